// File: doc/BRIEF.md
# Disc Head Recalibrate Sequencer

This block runs the recalibrate sequence of a disc drive's head positioner. It takes the carriage from whatever cylinder it is on back to the home reference at cylinder 0. A recalibrate strobe is acted on only while the positioner is idle, which means ready and settled. An accepted strobe first produces one cycle of clear pulses. These pulses zero the cylinder address registers, the head offset registers and the seek-check status, and they set the match flag.

After the clear cycle, the carriage slews backward while the servo signal is present. When the servo signal is lost at the outer guard band, the carriage slews forward instead. When the servo signal returns, its rising edge ends the coarse phase and fine positioning is enabled, provided the retract input is low. Detection of track center starts a settle delay, and the end of that delay restores ready and raises the ready attention flag.

A watchdog covers the whole sequence. If it runs out, all motion enables drop, a timeout fault is raised and the block returns to idle. The strobe, servo-present and track-center inputs are asynchronous and each passes through two synchronizer flops. Delays are counted in clock ticks.

States and transitions (the package type `hrs_state_e`):

- `ST_IDLE` → `ST_CLEAR` on a rising recalibrate strobe.
- `ST_CLEAR` → `ST_REVERSE` if servo is present, otherwise → `ST_FORWARD`.
- `ST_REVERSE` → `ST_FORWARD` when servo is lost.
- `ST_FORWARD` → `ST_FINE` on a rising edge of servo.
- `ST_FINE` → `ST_SETTLE` on track center while fine positioning is enabled.
- `ST_SETTLE` → `ST_IDLE` after `SETTLE_TICKS` cycles.
- Any state other than idle → `ST_IDLE` on watchdog expiry. This transition has priority over all others.

Top module: `head_recal_seq`

## Requirements
- R1: After reset: ready=1, settled=1, busy=0, match=0, attention=0, fault=0, and all slew, fine and clear outputs are 0.
- R2: A recalibrate strobe is accepted only in idle (ready=1 and settled=1). A strobe edge arriving while the sequence runs produces no clear pulse and no change to the outputs.
- R3: An accepted strobe gives one cycle with clr_cyl, clr_offset and clr_seek_chk all high. That cycle begins on the third rising clock edge after the strobe input rises. From the next cycle, match stays at 1.
- R4: In the cycle after the clear pulse, slew_rev is high if servo is present and slew_fwd is high otherwise. A fall of servo during reverse slew switches to slew_fwd on the third clock edge after the fall.
- R5: A rise of servo during forward slew enables fine_pos on the third clock edge after the rise. fine_pos is high only while retract=0. With retract=1, fine_pos stays 0 and track center is ignored.
- R6: From the clear cycle until the sequence ends, busy=1 and ready=0. The clear cycle also resets the attention and fault flags to 0.
- R7: Track center during fine positioning raises settled on the third edge after it rises. Ready returns SETTLE_TICKS cycles later, together with busy=0 and attention=1.
- R8: If ready has not returned within WDOG_TICKS cycles counted from the clear cycle, the block returns to idle on cycle WDOG_TICKS. On that return, all enables are 0 and the fault flag is 1. Expiry in the same cycle as the end of settling counts as a timeout.
- R9: At most one of slew_rev, slew_fwd and fine_pos is high in any cycle.
- R10: A strobe held high starts only one sequence. Staying high after the return to idle gives no further clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recal_req | input | 1 | Recalibrate strobe (asynchronous) |
| servo_present | input | 1 | Servo signal present (asynchronous) |
| track_center | input | 1 | Track center detected (asynchronous) |
| retract | input | 1 | Retract in progress; blocks fine positioning |
| slew_rev | output | 1 | Reverse constant-velocity slew enable |
| slew_fwd | output | 1 | Forward constant-velocity slew enable |
| fine_pos | output | 1 | Fine position loop enable |
| clr_cyl | output | 1 | Clear pulse to target and present cylinder registers |
| clr_offset | output | 1 | Clear pulse to offset magnitude and sign |
| clr_seek_chk | output | 1 | Clear pulse to seek-check status |
| match | output | 1 | Target and present cylinder agree |
| busy | output | 1 | Busy status bit 0 |
| ready | output | 1 | Access ready; commands permitted |
| settled | output | 1 | Heads settled on track |
| attn_ready | output | 1 | Attention: access ready returned |
| timeout_fault | output | 1 | Watchdog expired during the sequence |

## Verification
The bench builds the block with WDOG_TICKS=40 and SETTLE_TICKS=4. With these values, a full run of the sequence and the watchdog both fit within a few dozen cycles. The bench sweeps the moment of track center across every cycle of fine positioning. This brings within reach the boundary where the end of settling meets watchdog expiry, and the cases where track center comes too late to beat it. Further sweeps vary the servo timing, stall the sequence in reverse slew, forward slew and fine positioning, and repeat runs with retract held high. Throughout each run, the bench sends a stray strobe while the sequence is busy.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CLEAR   = 3'd1,
        ST_REVERSE = 3'd2,
        ST_FORWARD = 3'd3,
        ST_FINE    = 3'd4,
        ST_SETTLE  = 3'd5
    } hrs_state_e;
endpackage

// File: rtl/hrs_sync.sv
module hrs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pipe[s] <= '0;
            else if (s == 0)
                pipe[s] <= din;
            else
                pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/hrs_edge.sv
module hrs_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/hrs_tick.sv
module hrs_tick #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/head_recal_seq.sv
module head_recal_seq
    import hrs_pkg::*;
#(
    parameter int WDOG_TICKS   = 83_350_000,
    parameter int SETTLE_TICKS = 65_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic recal_req,
    input  logic servo_present,
    input  logic track_center,
    input  logic retract,
    output logic slew_rev,
    output logic slew_fwd,
    output logic fine_pos,
    output logic clr_cyl,
    output logic clr_offset,
    output logic clr_seek_chk,
    output logic match,
    output logic busy,
    output logic ready,
    output logic settled,
    output logic attn_ready,
    output logic timeout_fault
);
    localparam int NSYNC = 3;

    hrs_state_e state_q, state_d;
    logic [NSYNC-1:0] async_in, sync_out;
    logic [1:0] rise_v;
    logic cmd_rise, servo_s, servo_rise, tc_s;
    logic wd_exp, settle_done;
    logic match_q, attn_q, fault_q;

    assign async_in = {track_center, servo_present, recal_req};

    hrs_sync #(.WIDTH(NSYNC), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(async_in), .dout(sync_out)
    );

    assign servo_s = sync_out[1];
    assign tc_s    = sync_out[2];

    hrs_edge #(.WIDTH(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .level(sync_out[1:0]), .rise(rise_v)
    );

    assign cmd_rise   = rise_v[0];
    assign servo_rise = rise_v[1];

    hrs_tick #(.LIMIT(WDOG_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE), .expired(wd_exp)
    );

    hrs_tick #(.LIMIT(SETTLE_TICKS)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_SETTLE), .expired(settle_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_rise) state_d = ST_CLEAR;
            ST_CLEAR:   state_d = servo_s ? ST_REVERSE : ST_FORWARD;
            ST_REVERSE: if (!servo_s) state_d = ST_FORWARD;
            ST_FORWARD: if (servo_rise) state_d = ST_FINE;
            ST_FINE:    if (tc_s && !retract && match_q) state_d = ST_SETTLE;
            ST_SETTLE:  if (settle_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (state_q != ST_IDLE && wd_exp)
            state_d = ST_IDLE;
    end

    // flags kept across the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            attn_q  <= 1'b0;
            fault_q <= 1'b0;
        end else if (state_q == ST_CLEAR) begin
            match_q <= 1'b1;
            attn_q  <= 1'b0;
            fault_q <= 1'b0;
        end else if (state_q != ST_IDLE && wd_exp) begin
            fault_q <= 1'b1;
        end else if (state_q == ST_SETTLE && settle_done) begin
            attn_q  <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        slew_rev     = (state_q == ST_REVERSE);
        slew_fwd     = (state_q == ST_FORWARD);
        fine_pos     = (state_q == ST_FINE) && !retract && match_q;
        clr_cyl      = (state_q == ST_CLEAR);
        clr_offset   = (state_q == ST_CLEAR);
        clr_seek_chk = (state_q == ST_CLEAR);
        ready        = (state_q == ST_IDLE);
        busy         = (state_q != ST_IDLE);
        settled      = (state_q == ST_IDLE) || (state_q == ST_SETTLE);
        match        = match_q;
        attn_ready   = attn_q;
        timeout_fault = fault_q;
    end

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slew_rev, slew_fwd, fine_pos}));

    assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cyl |-> $past(ready) && $past(settled));

    assert_clr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cyl |=> !clr_cyl && match);

    assert_rev_to_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slew_rev) |-> slew_fwd || ready);

    assert_attn_on_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && !timeout_fault) |-> attn_ready);

    assert_fault_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_fault) |-> ready && !slew_rev && !slew_fwd && !fine_pos);
endmodule

// File: tb/test_head_recal_seq.sv
module test_head_recal_seq;
    localparam int W   = 40;
    localparam int S   = 4;
    localparam int BIG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic recal_req = 1'b0, servo_present = 1'b1, track_center = 1'b0, retract = 1'b0;
    logic slew_rev, slew_fwd, fine_pos, clr_cyl, clr_offset, clr_seek_chk;
    logic match, busy, ready, settled, attn_ready, timeout_fault;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    head_recal_seq #(.WDOG_TICKS(W), .SETTLE_TICKS(S)) i_head_recal_seq (
        .clk(clk), .rst_n(rst_n), .recal_req(recal_req),
        .servo_present(servo_present), .track_center(track_center), .retract(retract),
        .slew_rev(slew_rev), .slew_fwd(slew_fwd), .fine_pos(fine_pos),
        .clr_cyl(clr_cyl), .clr_offset(clr_offset), .clr_seek_chk(clr_seek_chk),
        .match(match), .busy(busy), .ready(ready), .settled(settled),
        .attn_ready(attn_ready), .timeout_fault(timeout_fault)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    // a,b,c: cycle after the clear pulse at which servo falls, servo rises, track center rises (-1 = never)
    task automatic run_case(input int a, input int b, input int c, input logic ret, input bit hold);
        int ta, tb, tcs, tend;
        bit to;
        servo_present = 1'b1; track_center = 1'b0; retract = ret; recal_req = 1'b0;
        repeat (4) @(negedge clk);
        recal_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(clr_cyl && clr_offset && clr_seek_chk, "R3 clear pulse", {clr_cyl, clr_offset, clr_seek_chk}, 3'b111);
        chk(busy && !ready, "R6 busy in clear", {busy, ready}, 2'b10);
        ta   = (a < 0) ? BIG : a + 3;
        tb   = (a < 0 || b < 0) ? BIG : b + 3;
        tcs  = (c < 0 || ret || tb == BIG) ? BIG : c + 3;
        tend = (tcs + S < W) ? tcs + S : W;
        to   = (tend == W);
        for (int t = 1; t <= W + 3; t++) begin
            logic e_rev, e_fwd, e_fine, e_set, e_idle;
            @(negedge clk);
            e_idle = (t >= tend);
            e_set  = !e_idle && (t >= tcs);
            e_fine = !e_idle && !e_set && (t >= tb) && !ret;
            e_fwd  = !e_idle && (t >= ta) && (t < tb);
            e_rev  = !e_idle && (t < ta);
            if (t == 1) begin
                chk(match, "R3 match held", match, 1);
                chk(!attn_ready && !timeout_fault, "R6 R8 flags cleared", {attn_ready, timeout_fault}, 0);
            end
            chk(slew_rev == e_rev && slew_fwd == e_fwd, "R4 slew", {slew_rev, slew_fwd}, {e_rev, e_fwd});
            chk(fine_pos == e_fine, "R5 fine", fine_pos, e_fine);
            chk(settled == (e_set || e_idle), "R7 settled", settled, e_set || e_idle);
            chk(ready == e_idle && busy == !e_idle, (to && e_idle) ? "R8 ready" : "R6 R7 ready/busy",
                {ready, busy}, {e_idle, !e_idle});
            chk(!clr_cyl && !clr_offset && !clr_seek_chk, "R2 no clear", {clr_cyl, clr_offset, clr_seek_chk}, 0);
            chk($countones({slew_rev, slew_fwd, fine_pos}) <= 1, "R9 exclusive",
                {slew_rev, slew_fwd, fine_pos}, 0);
            if (!hold) begin
                if (t == 1) recal_req = 1'b0;
                if (t == 4) recal_req = 1'b1;
                if (t == 6) recal_req = 1'b0;
            end
            if (t == a) servo_present = 1'b0;
            if (t == b) servo_present = 1'b1;
            if (t == c) track_center = 1'b1;
        end
        chk(timeout_fault == to, "R8 fault flag", timeout_fault, to);
        chk(attn_ready == !to, "R7 attention", attn_ready, !to);
        if (hold) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                chk(!clr_cyl && ready, "R10 held strobe", {clr_cyl, ready}, 2'b01);
            end
        end
        recal_req = 1'b0; servo_present = 1'b1; track_center = 1'b0; retract = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && settled && !busy && !match && !attn_ready && !timeout_fault,
            "R1 reset flags", {ready, settled, busy, match, attn_ready, timeout_fault}, 6'b110000);
        chk(!slew_rev && !slew_fwd && !fine_pos && !clr_cyl && !clr_offset && !clr_seek_chk,
            "R1 reset enables", {slew_rev, slew_fwd, fine_pos, clr_cyl}, 0);
        // track-center timing sweep across the watchdog boundary (R7, R8)
        for (int c = 7; c < W; c++) run_case(2, 6, c, 1'b0, 1'b0);
        // servo timing sweep (R4, R5)
        for (int a = 1; a <= 5; a++) run_case(a, a + 2, a + 4, 1'b0, 1'b0);
        // stalls and retract (R5, R8)
        run_case(-1, -1, -1, 1'b0, 1'b0);
        run_case(2, -1, -1, 1'b0, 1'b0);
        run_case(2, 6, -1, 1'b0, 1'b0);
        run_case(2, 6, 8, 1'b1, 1'b0);
        // held strobe (R10)
        run_case(3, 5, 8, 1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule